// File: doc/BRIEF.md
# Vector Float-to-Colour Packer

This unit converts a 128-bit vector of four IEEE-754 single-precision values into a packed 32-bit colour word. Each value is limited to the unit interval, scaled to an 8-bit channel and placed in its byte of the word. The word is returned in the least significant 32 bits of a 128-bit result whose upper 96 bits are zero. A later merge stage reads the packed word from that position.

A 5-bit immediate comes with each request. Its upper three bits select the packing format. Its lower two bits belong to the merge stage, and this unit ignores them. Only format code 0 (colour) is built. Any other code returns the source vector unchanged and raises an unhandled flag.

The unit registers its result once, so the output follows an accepted request by one clock. Values outside the unit range are limited without any report: the unit has no saturation output and no status of its own.

Top module: `ckpk_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `unhandled` and `out_vec` are all zero.
- R2: A request taken with `in_valid` high at a rising edge produces `out_valid` high after that same edge, for exactly one cycle. With no request, `out_valid` stays low.
- R3: In colour format, bits 127:32 of `out_vec` are zero. In bits 31:0, lane 3 of the source is placed in bits 31:24 (alpha), lane 0 in bits 23:16 (red), lane 1 in bits 15:8 (green) and lane 2 in bits 7:0 (blue). Lane 0 is source bits 127:96, lane 1 is bits 95:64, lane 2 is bits 63:32 and lane 3 is bits 31:0.
- R4: A value v in the range [0,1] becomes round(v*255), with exact halves rounded up. So 0.0 gives 0x00, 0.5 gives 0x80, 0.75 gives 0xBF and 1.0 gives 0xFF.
- R5: Values above 1.0, including +infinity, give 0xFF. Negative values, including -0.0 and -infinity, give 0x00.
- R6: A NaN of either sign gives 0x00. A denormal input gives 0x00.
- R7: The format code is `fmt_imm[4:2]`, and code 0 selects colour packing. `fmt_imm[1:0]` has no effect on the result or on the flag.
- R8: For format codes 1 to 7, `out_vec` equals the source vector and `unhandled` is 1.
- R9: For format code 0, `unhandled` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Four float lanes; lane 0 is bits 127:96 |
| fmt_imm | input | 5 | Immediate; bits 4:2 select the format |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| out_vec | output | 128 | Packed or passed-through result |
| unhandled | output | 1 | Format code is not implemented |

## Verification
The colour path is driven with one vector of distinct in-range values. This shows the lane-to-byte mapping and the rounding at exact halves and quarter steps. Single-lane vectors separate a misplaced channel from a wrong scale. A value near 1/255 and the smallest normal value probe the low end of the shift-and-round logic.

Out-of-range vectors (values above one, negatives, both infinities) are contrasted with NaNs and denormals to separate clamping from special-value handling. Repeating a colour request with nonzero low immediate bits, and sweeping codes 1 to 7 over a fixed pattern, separates format decode from the pass-through path.

// File: rtl/ckpk_pkg.sv
package ckpk_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 32;
    localparam int VEC_W   = LANES * LANE_W;
    localparam int CH_W    = 8;
    localparam int IMM_W   = 5;
    localparam int FMT_W   = 3;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int BIAS    = 127;
    localparam int CH_MAX  = (1 << CH_W) - 1;

    localparam logic [FMT_W-1:0] FMT_COLOR = '0;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } f32_t;

    function automatic logic [FMT_W-1:0] fmt_of(input logic [IMM_W-1:0] imm);
        return imm[IMM_W-1 -: FMT_W];
    endfunction
endpackage

// File: rtl/ckpk_chan.sv
module ckpk_chan
    import ckpk_pkg::*;
(
    input  logic [LANE_W-1:0] fval,
    output logic [CH_W-1:0]   chan
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 64;
    localparam int SH_BASE = BIAS + MAN_W;
    localparam int SH_MAX  = SIG_W + CH_W;

    f32_t f;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rounded;
    int unsigned sh;

    assign f = f32_t'(fval);

    always_comb begin
        prod    = PROD_W'({1'b1, f.man}) * PROD_W'(CH_MAX);
        sh      = 0;
        rounded = '0;
        chan    = '0;
        if (f.exp == '1 && f.man != '0) begin
            chan = '0;
        end else if (f.sign) begin
            chan = '0;
        end else if (f.exp == '0) begin
            chan = '0;
        end else if (int'(f.exp) >= BIAS) begin
            chan = CH_W'(CH_MAX);
        end else begin
            sh = unsigned'(SH_BASE - int'(f.exp));
            if (sh <= SH_MAX) begin
                rounded = (prod + (PROD_W'(1) << (sh - 1))) >> sh;
                chan    = rounded[CH_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ckpk_color.sv
module ckpk_color
    import ckpk_pkg::*;
(
    input  logic [VEC_W-1:0] src,
    output argb_t            word
);
    logic [CH_W-1:0] ch [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ckpk_chan u_chan (
            .fval (src[VEC_W-1-i*LANE_W -: LANE_W]),
            .chan (ch[i])
        );
    end

    assign word.r = ch[0];
    assign word.g = ch[1];
    assign word.b = ch[2];
    assign word.a = ch[3];
endmodule

// File: rtl/ckpk_unit.sv
module ckpk_unit
    import ckpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [IMM_W-1:0]   fmt_imm,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec,
    output logic               unhandled
);
    argb_t            word;
    logic             is_color;
    logic [VEC_W-1:0] nxt_vec;

    ckpk_color u_color (
        .src  (src_vec),
        .word (word)
    );

    assign is_color = (fmt_of(fmt_imm) == FMT_COLOR);
    assign nxt_vec  = is_color ? {{(VEC_W-LANE_W){1'b0}}, LANE_W'(word)} : src_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            unhandled <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec   <= nxt_vec;
                unhandled <= !is_color;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && unhandled) |-> (out_vec == $past(src_vec)));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !unhandled) |-> (out_vec[VEC_W-1:LANE_W] == '0));

    // R7
    code_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (unhandled == ($past(fmt_imm[IMM_W-1 -: FMT_W]) != '0)));
endmodule

// File: tb/ckpk_unit_tb_top.sv
module ckpk_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] src_vec;
    logic [4:0]   fmt_imm;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         unhandled;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ckpk_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .fmt_imm(fmt_imm), .out_valid(out_valid), .out_vec(out_vec),
        .unhandled(unhandled)
    );

    localparam logic [31:0] F_ONE  = 32'h3F800000;
    localparam logic [31:0] F_HALF = 32'h3F000000;
    localparam logic [31:0] F_ZERO = 32'h00000000;
    localparam logic [31:0] F_Q3   = 32'h3F400000;
    localparam logic [31:0] F_Q1   = 32'h3E800000;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [127:0] s, input logic [4:0] imm);
        @(negedge clk);
        in_valid = 1'b1;
        src_vec  = s;
        fmt_imm  = imm;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; src_vec = '0; fmt_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid in reset", {127'b0, out_valid}, 128'd0);
        chk("R1 out_vec in reset", out_vec, 128'd0);
        chk("R1 unhandled in reset", {127'b0, unhandled}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", {127'b0, out_valid}, 128'd0);
        chk("R1 out_vec after reset", out_vec, 128'd0);
    endtask

    task automatic t_basic();
        run_op({F_ONE, F_HALF, F_ZERO, F_Q3}, 5'b00000);
        chk("R2 out_valid after request", {127'b0, out_valid}, 128'd1);
        chk("R4 R3 mixed vector", out_vec, {96'b0, 32'hBFFF8000});
        chk("R9 colour flag", {127'b0, unhandled}, 128'd0);
        @(negedge clk);
        chk("R2 out_valid single pulse", {127'b0, out_valid}, 128'd0);
    endtask

    task automatic t_mapping();
        run_op({F_Q1, F_ZERO, F_ZERO, F_ZERO}, 5'b00000);
        chk("R3 red lane 0", out_vec, {96'b0, 32'h00400000});
        run_op({F_ZERO, F_ONE, F_ZERO, F_ZERO}, 5'b00000);
        chk("R3 green lane 1", out_vec, {96'b0, 32'h0000FF00});
        run_op({F_ZERO, F_ZERO, 32'h3B808081, F_ZERO}, 5'b00000);
        chk("R4 blue lane 2 near 1/255", out_vec, {96'b0, 32'h00000001});
        run_op({32'h00800000, F_ZERO, F_ZERO, F_ONE}, 5'b00000);
        chk("R3 alpha lane 3, R4 min normal", out_vec, {96'b0, 32'hFF000000});
    endtask

    task automatic t_clamp();
        run_op({32'h40000000, 32'hBF000000, 32'h7F800000, 32'hFF800000}, 5'b00000);
        chk("R5 clamp high/low/inf", out_vec, {96'b0, 32'h00FF00FF});
        run_op({32'h80000000, 32'h42C80000, F_ZERO, F_ZERO}, 5'b00000);
        chk("R5 neg zero and 100.0", out_vec, {96'b0, 32'h0000FF00});
    endtask

    task automatic t_special();
        run_op({32'h7FC00000, 32'h00000001, 32'hFFC00000, F_ONE}, 5'b00000);
        chk("R6 nan and denormal", out_vec, {96'b0, 32'hFF000000});
        run_op({32'h007FFFFF, 32'h7F800001, F_ZERO, F_ZERO}, 5'b00000);
        chk("R6 max denormal and signalling nan", out_vec, 128'd0);
    endtask

    task automatic t_low_bits();
        for (int k = 1; k < 4; k++) begin
            run_op({F_ONE, F_HALF, F_ZERO, F_Q3}, 5'(k));
            chk("R7 low imm bits ignored", out_vec, {96'b0, 32'hBFFF8000});
            chk("R7 low imm bits flag", {127'b0, unhandled}, 128'd0);
        end
    endtask

    task automatic t_unhandled();
        logic [127:0] pat;
        pat = 128'h3F800000_C0000000_7FC00000_12345678;
        for (int c = 1; c < 8; c++) begin
            run_op(pat ^ {4{32'(c)}}, {3'(c), 2'b10});
            chk("R8 passthrough", out_vec, pat ^ {4{32'(c)}});
            chk("R8 unhandled flag", {127'b0, unhandled}, 128'd1);
        end
        run_op({F_ONE, F_HALF, F_ZERO, F_Q3}, 5'b00000);
        chk("R9 flag clears on colour", {127'b0, unhandled}, 128'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mapping();
        t_clamp();
        t_special();
        t_low_bits();
        t_unhandled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule